// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-frame SPI master that software drives through a 32-bit register port with five word-aligned locations. Software picks the frame size (8 or 16 bits) and the clock polarity and phase in a configuration word. It picks one of eight peripheral select lines, and decides whether that line is driven, in a control word. Each write to the outbound data location starts one full-duplex frame, shifted most significant bit first.

The serial clock is paced by a single-cycle enable pulse from an external prescaler. Each pulse moves the serial clock by one half period. When the last bit has been exchanged, a sticky completion flag is raised. The word captured from the peripheral can then be read from the inbound data location.

Software clears the completion flag by writing anything to its location. A new launch also clears it. The master keeps its own busy state and ignores a launch attempted while a frame is still running.

Top module: `spi_mm_master`

## Requirements
- R1: After reset every select line is high, the completion flag reads 0, the configuration word reads 0 (8-bit frames, idle clock low, sample on the leading edge) and the serial clock is low.
- R2: The control word at byte offset 0x00 holds a drive bit at bit 0 and a line index at bits [4:2]. While the drive bit is 1, exactly the indexed select line is low. While it is 0, all eight lines are high, and this holds whether or not a frame is running.
- R3: A write to byte offset 0x08 while idle launches exactly one frame. The frame has 16 serial clock edges when configuration bit 5 is 0, and 32 edges when bit 5 is 1.
- R4: Outbound data is taken from bits [7:0] (8-bit frame) or bits [15:0] (16-bit frame) of the launching write, sent most significant bit first. Higher bits of the write are ignored.
- R5: Configuration bit 11 sets the idle level of the serial clock, and the clock returns to that level after each frame. Configuration bit 12 = 0 samples on the leading edge and changes data on the trailing edge; bit 12 = 1 changes data on the leading edge and samples on the trailing edge.
- R6: After a frame, a read at byte offset 0x0C returns the captured word in its low 8 or 16 bits, with all higher bits zero.
- R7: Bit 0 at byte offset 0x10 is a sticky completion flag. It is set when a frame ends. It is cleared by any write to 0x10, or by a launch.
- R8: If a write to 0x10 is captured in the same clock cycle that a frame ends, the completion flag ends up set.
- R9: A write to 0x08 while a frame is running is ignored: the running frame is not disturbed and no further frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrite | input | 1 | Write strobe for the register port |
| regAddr | input | 5 | Byte address; bits [4:2] select the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the addressed register (combinational) |
| sclkTick | input | 1 | Half-period enable pulse from the prescaler |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to the peripheral |
| spiMiso | input | 1 | Serial data from the peripheral |
| spiCsN | output | 8 | Active-low select lines |

## Verification
The completion flag has two writers that can act in the same cycle: the final serial clock edge of a frame sets it, and a software write to the cause location clears it. The bench runs the serial clock enable every cycle so that the frame end lands on a known clock edge. It then times the clearing write so that it is captured on exactly that edge, and expects the flag to read 1 afterwards. A write landing one edge later is used as the contrasting case, and must leave the flag at 0.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;
  localparam int FRAME_MAX = 16;
  localparam int FRAME_MIN = 8;

  typedef struct packed {
    logic                 launch;
    logic                 wide;
    logic                 cpol;
    logic                 cpha;
    logic [FRAME_MAX-1:0] txWord;
  } dpCmd_t;
endpackage

// File: rtl/spi_mm_shift.sv
module spi_mm_shift
  import spi_mm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCmd_t               cmd,
  input  logic                 idleCpol,
  input  logic                 sclkTick,
  input  logic                 spiMiso,
  output logic                 spiSclk,
  output logic                 spiMosi,
  output logic                 busy,
  output logic                 frameDone,
  output logic [FRAME_MAX-1:0] rxWord
);
  localparam int CNT_W = $clog2(2 * FRAME_MAX);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(2 * FRAME_MAX - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(2 * FRAME_MIN - 1);

  logic                 wideQ, cpolQ, cphaQ, phase;
  logic [CNT_W-1:0]     edgeCnt;
  logic [FRAME_MAX-1:0] txSh, rxSh;
  logic [CNT_W-1:0]     lastEdge;
  logic                 leading, sampleEdge, shiftEdge;

  assign lastEdge   = wideQ ? LAST_WIDE : LAST_NARROW;
  assign leading    = ~edgeCnt[0];
  assign sampleEdge = cphaQ ? ~leading : leading;
  assign shiftEdge  = cphaQ ? (leading && edgeCnt != '0) : ~leading;
  assign frameDone  = busy && sclkTick && (edgeCnt == lastEdge);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      wideQ   <= 1'b0;
      cpolQ   <= 1'b0;
      cphaQ   <= 1'b0;
      phase   <= 1'b0;
      edgeCnt <= '0;
      txSh    <= '0;
      rxSh    <= '0;
    end else if (cmd.launch) begin
      busy    <= 1'b1;
      wideQ   <= cmd.wide;
      cpolQ   <= cmd.cpol;
      cphaQ   <= cmd.cpha;
      phase   <= 1'b0;
      edgeCnt <= '0;
      txSh    <= cmd.txWord;
      rxSh    <= '0;
    end else if (busy && sclkTick) begin
      phase   <= ~phase;
      edgeCnt <= edgeCnt + 1'b1;
      if (sampleEdge) rxSh <= {rxSh[FRAME_MAX-2:0], spiMiso};
      if (shiftEdge)  txSh <= {txSh[FRAME_MAX-2:0], 1'b0};
      if (edgeCnt == lastEdge) busy <= 1'b0;
    end
  end

  assign spiSclk = busy ? (cpolQ ^ phase) : idleCpol;
  assign spiMosi = txSh[FRAME_MAX-1];
  assign rxWord  = rxSh;

  // R3: the edge counter never runs past the frame length
  p_edge_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (edgeCnt <= lastEdge));
  // R5: an even number of clock moves leaves the clock at its idle level
  p_clock_rest_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> (phase == 1'b0));
  // R9: the control side never launches into a running frame
  p_no_launch_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmd.launch);
  // R3: a launch always starts a frame
  p_launch_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.launch |=> busy);
endmodule

// File: rtl/spi_mm_ctrl.sv
module spi_mm_ctrl
  import spi_mm_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  input  logic                 busy,
  input  logic                 frameDone,
  input  logic [FRAME_MAX-1:0] rxWord,
  output dpCmd_t               cmd,
  output logic                 idleCpol,
  output logic [NUM_CS-1:0]    spiCsN
);
  localparam int IDX_W    = $clog2(NUM_CS);
  localparam int CS_LSB   = 2;
  localparam int WIDE_BIT = 5;
  localparam int CPOL_BIT = 11;
  localparam int CPHA_BIT = 12;
  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_CFG   = 3'd1;
  localparam logic [2:0] SEL_DOUT  = 3'd2;
  localparam logic [2:0] SEL_DIN   = 3'd3;
  localparam logic [2:0] SEL_CAUSE = 3'd4;

  logic             csEnable, cfgWide, cfgCpol, cfgCpha, doneFlag;
  logic [IDX_W-1:0] csIndex;
  logic [2:0]       wordSel;
  logic             wrCtrl, wrCfg, wrDout, wrCause;

  assign wordSel = regAddr[4:2];
  assign wrCtrl  = regWrite && (wordSel == SEL_CTRL);
  assign wrCfg   = regWrite && (wordSel == SEL_CFG);
  assign wrDout  = regWrite && (wordSel == SEL_DOUT);
  assign wrCause = regWrite && (wordSel == SEL_CAUSE);

  wire unusedBits = &{1'b0, regAddr[1:0], regWdata[DATA_W-1:FRAME_MAX]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csEnable <= 1'b0;
      csIndex  <= '0;
      cfgWide  <= 1'b0;
      cfgCpol  <= 1'b0;
      cfgCpha  <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      if (wrCtrl) begin
        csEnable <= regWdata[0];
        csIndex  <= regWdata[CS_LSB +: IDX_W];
      end
      if (wrCfg) begin
        cfgWide <= regWdata[WIDE_BIT];
        cfgCpol <= regWdata[CPOL_BIT];
        cfgCpha <= regWdata[CPHA_BIT];
      end
      if (frameDone)                    doneFlag <= 1'b1;
      else if (wrCause || cmd.launch)   doneFlag <= 1'b0;
    end
  end

  always_comb begin
    cmd.launch = wrDout && !busy;
    cmd.wide   = cfgWide;
    cmd.cpol   = cfgCpol;
    cmd.cpha   = cfgCpha;
    cmd.txWord = cfgWide ? regWdata[FRAME_MAX-1:0]
                         : {regWdata[FRAME_MIN-1:0], {(FRAME_MAX-FRAME_MIN){1'b0}}};
  end
  assign idleCpol = cfgCpol;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spiCsN[i] = ~(csEnable && (csIndex == IDX_W'(i)));
  end

  always_comb begin
    regRdata = '0;
    case (wordSel)
      SEL_CTRL: begin
        regRdata[0]                = csEnable;
        regRdata[CS_LSB +: IDX_W]  = csIndex;
      end
      SEL_CFG: begin
        regRdata[WIDE_BIT] = cfgWide;
        regRdata[CPOL_BIT] = cfgCpol;
        regRdata[CPHA_BIT] = cfgCpha;
      end
      SEL_DIN:   regRdata[FRAME_MAX-1:0] = rxWord;
      SEL_CAUSE: regRdata[0] = doneFlag;
      default:   regRdata = '0;
    endcase
  end

  // R2: at most one select line is low
  p_cs_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~spiCsN));
  // R2: with the drive bit clear no line is low
  p_cs_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !csEnable |-> (&spiCsN));
  // R8: a frame end always leaves the flag set, even against a clear
  p_done_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> doneFlag);
  // R7: a clear with no frame end leaves the flag low
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrCause && !frameDone) |=> !doneFlag);
endmodule

// File: rtl/spi_mm_master.sv
module spi_mm_master
  import spi_mm_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sclkTick,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic [NUM_CS-1:0] spiCsN
);
  dpCmd_t               cmd;
  logic                 busy, frameDone, idleCpol;
  logic [FRAME_MAX-1:0] rxWord;

  spi_mm_ctrl #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy),
    .frameDone(frameDone), .rxWord(rxWord), .cmd(cmd),
    .idleCpol(idleCpol), .spiCsN(spiCsN));

  spi_mm_shift u_shift (
    .clk(clk), .rstN(rstN), .cmd(cmd), .idleCpol(idleCpol),
    .sclkTick(sclkTick), .spiMiso(spiMiso), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .busy(busy), .frameDone(frameDone), .rxWord(rxWord));
endmodule

// File: tb/spi_mm_master_bench.sv
module spi_mm_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_DOUT = 5'h08,
                         A_DIN = 5'h0C, A_CAUSE = 5'h10;

  logic clk = 0, rstN = 0, regWrite = 0, sclkTick = 0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic spiSclk, spiMosi, spiMiso;
  logic [7:0] spiCsN;

  int checks = 0, errors = 0;
  int tickDiv = 2, tickCnt = 0;

  logic slArmed = 0, slCpol = 0, slCpha = 0;
  int   slEdge = 0;
  logic [15:0] slTx = '0, slRx = '0;

  spi_mm_master u_spi_mm_master (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclkTick(sclkTick),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tickCnt >= tickDiv - 1) begin sclkTick <= 1'b1; tickCnt <= 0; end
    else begin sclkTick <= 1'b0; tickCnt <= tickCnt + 1; end
  end

  assign spiMiso = slTx[15];

  // peripheral model: samples and shifts per the requested mode
  always @(spiSclk) begin
    if (slArmed) begin
      automatic logic lead = (spiSclk != slCpol);
      if ((!slCpha && lead) || (slCpha && !lead)) slRx = {slRx[14:0], spiMosi};
      if ((!slCpha && !lead) || (slCpha && lead && slEdge != 0)) slTx = slTx << 1;
      slEdge++;
    end
  end

  function automatic logic [31:0] fitWord(input bit wide, input logic [15:0] w);
    return wide ? {16'h0, w} : {24'h0, w[7:0]};
  endfunction

  function automatic logic [7:0] csExpect(input bit en, input int idx);
    return en ? ~(8'd1 << idx) : 8'hFF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); regWrite = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWrite = 0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic setup(input bit wide, cpol, cpha, input int idx, input bit en, input logic [15:0] slw);
    busWrite(A_CFG, {19'b0, cpha, cpol, 5'b0, wide, 5'b0});
    busWrite(A_CTRL, {27'b0, idx[2:0], 1'b0, en});
    slCpol = cpol; slCpha = cpha; slEdge = 0; slRx = '0;
    slTx = wide ? slw : {slw[7:0], 8'h00};
    slArmed = 1;
  endtask

  task automatic waitDone(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int n = 0; n < 4000; n++) begin
      busRead(A_CAUSE, v);
      if (v[0]) begin ok = 1; break; end
    end
  endtask

  task automatic runFrame(input bit wide, cpol, cpha, input int idx, input bit en,
                          input logic [15:0] txw, slw, input int div);
    logic [31:0] v; bit ok;
    tickDiv = div;
    setup(wide, cpol, cpha, idx, en, slw);
    busWrite(A_DOUT, {$urandom() & 32'hFFFF_0000} | {16'h0, txw});
    busRead(A_CAUSE, v);
    chk(v == 0, "R7 launch clears flag", v, 0);
    waitDone(ok);
    slArmed = 0;
    chk(ok, "R7 flag sets at frame end", {31'b0, ok}, 1);
    chk({16'h0, slRx} == fitWord(wide, txw), "R4 outbound bits", {16'h0, slRx}, fitWord(wide, txw));
    chk(slEdge == (wide ? 32 : 16), "R3 edge count", slEdge, wide ? 32 : 16);
    chk(spiSclk == cpol, "R5 clock idle level", {31'b0, spiSclk}, {31'b0, cpol});
    busRead(A_DIN, v);
    chk(v == fitWord(wide, slw), "R6 inbound word", v, fitWord(wide, slw));
    chk(spiCsN == csExpect(en, idx), "R2 select lines", {24'h0, spiCsN}, {24'h0, csExpect(en, idx)});
    busWrite(A_CAUSE, $urandom());
    busRead(A_CAUSE, v);
    chk(v == 0, "R7 write clears flag", v, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v; bit ok;
    int unsigned seedInit;
    seedInit = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    chk(spiCsN == 8'hFF, "R1 select lines high", {24'h0, spiCsN}, 32'hFF);
    chk(spiSclk == 1'b0, "R1 clock low", {31'b0, spiSclk}, 0);
    busRead(A_CAUSE, v); chk(v == 0, "R1 flag clear", v, 0);
    busRead(A_CFG, v);   chk(v == 0, "R1 config zero", v, 0);
    busRead(A_CTRL, v);  chk(v == 0, "R1 control zero", v, 0);

    // R2 every select index, driven and not driven
    for (int i = 0; i < 8; i++) begin
      busWrite(A_CTRL, {27'b0, 3'(i), 1'b0, 1'b1});
      @(negedge clk);
      chk(spiCsN == csExpect(1, i), "R2 indexed line low", {24'h0, spiCsN}, {24'h0, csExpect(1, i)});
      busWrite(A_CTRL, {27'b0, 3'(i), 1'b0, 1'b0});
      @(negedge clk);
      chk(spiCsN == 8'hFF, "R2 drive bit off", {24'h0, spiCsN}, 32'hFF);
    end

    // directed corners: all modes, both sizes, extreme patterns (R3 R4 R5 R6)
    for (int m = 0; m < 4; m++) begin
      runFrame(0, m[1], m[0], m, 1, 16'h00A5, 16'h003C, 1);
      runFrame(1, m[1], m[0], 7 - m, 0, 16'h8001, 16'hFFFE, 3);
    end

    // random frames
    for (int k = 0; k < 24; k++) begin
      runFrame(1'($urandom()), 1'($urandom()), 1'($urandom()), int'($urandom() % 8),
               1'($urandom()), 16'($urandom()), 16'($urandom()), int'($urandom() % 4) + 1);
    end

    // R8: clear captured on the very edge where the frame ends
    tickDiv = 1;
    setup(0, 0, 0, 2, 1, 16'h0069);
    repeat (3) @(negedge clk);
    busWrite(A_DOUT, 32'h0000_00C3);
    repeat (14) @(negedge clk);
    busWrite(A_CAUSE, 32'h0);
    busRead(A_CAUSE, v);
    chk(v == 1, "R8 completion beats clear", v, 1);
    slArmed = 0;
    chk({16'h0, slRx} == 32'hC3, "R4 bits in coincidence frame", {16'h0, slRx}, 32'hC3);

    // R7 contrast: clear one edge after the end
    setup(0, 1, 1, 5, 1, 16'h0011);
    repeat (3) @(negedge clk);
    busWrite(A_DOUT, 32'h0000_005A);
    repeat (15) @(negedge clk);
    busWrite(A_CAUSE, 32'h0);
    busRead(A_CAUSE, v);
    chk(v == 0, "R7 clear after end", v, 0);
    slArmed = 0;

    // R9: second launch while running is ignored
    tickDiv = 4;
    setup(1, 0, 1, 1, 1, 16'h1234);
    busWrite(A_DOUT, 32'h0000_BEEF);
    repeat (6) @(negedge clk);
    busWrite(A_DOUT, 32'h0000_0F0F);
    waitDone(ok);
    repeat (100) @(negedge clk);
    slArmed = 0;
    chk({16'h0, slRx} == 32'hBEEF, "R9 running frame intact", {16'h0, slRx}, 32'hBEEF);
    chk(slEdge == 32, "R9 no extra frame edges", slEdge, 32);
    busRead(A_CAUSE, v);
    chk(v == 1, "R9 flag not cleared by ignored write", v, 1);
    busRead(A_DIN, v);
    chk(v == 32'h1234, "R9 inbound word", v, 32'h1234);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule